// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block keeps the pending-request vector, the in-service vector and a pointer to the level that currently has the lowest priority for a small interrupt controller. It captures requests on edges or on levels, removes masked levels, and weighs the best pending request against the levels already being serviced. The result drives an interrupt line and a winning-level output. An acknowledge sequencer answers with a pulse that moves the winner into service. A command decoder sends end-of-service, rotation and priority-setting commands, together with static mode inputs.

Priority is circular. The level just after the lowest-priority pointer ranks first, and the rest follow in ascending order with wrap-around. Moving the pointer rotates the whole order. Special mask mode lets any unmasked level through regardless of what is in service. Special nested mode lets a level that is in service request again. A poll read returns an encoded status word and counts as an acknowledge.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, the pending and in-service vectors are zero, the interrupt output is low, the pointer names level 7 (level 0 ranks first), and the winning level reads all ones when nothing is pending.
- R2: With normal masking, the interrupt output is high when the best unmasked pending level ranks strictly above every in-service level. A pending level at the same or a lower rank is held off, but `win_level` still reports it.
- R3: A set `mask_in` bit hides that level from the search. When `smm_en` is high, in-service levels block nothing, and only the masked levels are excluded.
- R4: With `level_mode` low, a pending bit sets only on a 0-to-1 change of its input and stays set while the input is held high. With `level_mode` high, the pending bit follows the input each clock.
- R5: An `ack_set` pulse while the interrupt output is high sets the in-service bit of the winning level and clears its pending bit.
- R6: Command code {R,SL,EOI}=001 (non-specific end) clears the highest-ranked in-service bit. In special mask mode it skips in-service bits whose mask bit is set. An `aeoi_pulse` does the same clearing.
- R7: Code 011 clears the in-service bit named by `cmd_level`.
- R8: Code 101 clears the same bit as code 001 and makes that level the lowest priority. Code 111 clears the bit at `cmd_level` and makes `cmd_level` the lowest priority.
- R9: Code 110 makes `cmd_level` the lowest priority (the next level up ranks first) without changing any in-service bit. Code 010 changes nothing.
- R10: Code 100 enables rotation on automatic end, and code 000 disables it. While it is enabled, an `aeoi_pulse` also makes the cleared level the lowest priority.
- R11: `poll_word` reads {1,0000,level} when the interrupt output is high and 0x00 otherwise. A `poll_rd` pulse acts as an acknowledge.
- R12: With `sfnm_en` high, a request at the same rank as the best in-service level raises the interrupt. Only strictly lower ranks are held off.
- R13: An `init_pulse` clears both vectors, returns the pointer to level 7, disables rotation on automatic end, and re-arms edge capture, so that an input already high is not captured until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_pulse | input | 1 | Start of initialization |
| level_mode | input | 1 | 1 selects level capture, 0 selects edge capture |
| sfnm_en | input | 1 | Special nested mode |
| smm_en | input | 1 | Special mask mode |
| mask_in | input | NLEV | Per-level mask, 1 blocks |
| req_in | input | NLEV | Request lines |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | {R,SL,EOI} command code |
| cmd_level | input | log2(NLEV) | Level operand of the command |
| ack_set | input | 1 | Acknowledge from the sequencer |
| aeoi_pulse | input | 1 | Automatic end-of-service pulse |
| poll_rd | input | 1 | Poll read strobe |
| int_out | output | 1 | Interrupt request to the processor |
| win_level | output | log2(NLEV) | Best pending unmasked level |
| poll_word | output | 8 | Poll status byte |
| irr_out | output | NLEV | Pending-request vector |
| isr_out | output | NLEV | In-service vector |

## Verification
The search is exercised with single requests, with pairs that straddle an in-service level, and with the same pairs after the pointer has been rotated, set explicitly or moved by an automatic end. This separates the fixed ranking from the circular one and shows that each command moves the pointer to the correct level. Held-high inputs, inputs that are dropped and raised again, and level-mode inputs separate edge capture from level capture. The same in-service state is then tried with special mask mode and special nested mode switched on and off, so that only the blocking rule differs between runs.

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NLEV = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init_pulse,
  input  logic                     level_mode,
  input  logic                     sfnm_en,
  input  logic                     smm_en,
  input  logic [NLEV-1:0]          mask_in,
  input  logic [NLEV-1:0]          req_in,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_code,
  input  logic [$clog2(NLEV)-1:0]  cmd_level,
  input  logic                     ack_set,
  input  logic                     aeoi_pulse,
  input  logic                     poll_rd,
  output logic                     int_out,
  output logic [$clog2(NLEV)-1:0]  win_level,
  output logic [7:0]               poll_word,
  output logic [NLEV-1:0]          irr_out,
  output logic [NLEV-1:0]          isr_out
);
  localparam int LW = $clog2(NLEV);
  localparam logic [2:0] C_NSEOI   = 3'b001;
  localparam logic [2:0] C_SEOI    = 3'b011;
  localparam logic [2:0] C_RNSEOI  = 3'b101;
  localparam logic [2:0] C_RAE_SET = 3'b100;
  localparam logic [2:0] C_RAE_CLR = 3'b000;
  localparam logic [2:0] C_RSEOI   = 3'b111;
  localparam logic [2:0] C_SETPRI  = 3'b110;

  typedef logic [LW-1:0] lvl_t;
  typedef logic [LW:0]   pos_t;

  logic [NLEV-1:0] irr_q, isr_q, req_q;
  lvl_t            ptr_q;
  logic            rot_aeoi_q;

  function automatic pos_t first_set(input logic [NLEV-1:0] v);
    first_set = pos_t'(NLEV);
    for (int i = NLEV - 1; i >= 0; i--)
      if (v[i]) first_set = pos_t'(i);
  endfunction

  lvl_t            base;
  logic [NLEV-1:0] pend, pend_r, isr_r, isr_eoi_r;
  assign base = ptr_q + lvl_t'(1);
  assign pend = irr_q & ~mask_in;

  for (genvar g = 0; g < NLEV; g++) begin : g_rot
    lvl_t src;
    assign src          = base + lvl_t'(g);
    assign pend_r[g]    = pend[src];
    assign isr_r[g]     = isr_q[src];
    assign isr_eoi_r[g] = isr_q[src] & ~(smm_en & mask_in[src]);
  end

  pos_t req_pos, isr_pos, eoi_pos;
  logic has_req, has_eoi, allowed;
  lvl_t eoi_lvl;
  assign req_pos = first_set(pend_r);
  assign isr_pos = first_set(isr_r);
  assign eoi_pos = first_set(isr_eoi_r);
  assign has_req = !req_pos[LW];
  assign has_eoi = !eoi_pos[LW];
  assign eoi_lvl = eoi_pos[LW-1:0] + base;
  assign allowed = smm_en  ? 1'b1 :
                   sfnm_en ? (req_pos <= isr_pos) : (req_pos < isr_pos);

  assign int_out   = has_req & allowed;
  assign win_level = has_req ? lvl_t'(req_pos[LW-1:0] + base) : '1;
  assign poll_word = int_out ? {1'b1, {(7-LW){1'b0}}, win_level} : 8'h00;
  assign irr_out   = irr_q;
  assign isr_out   = isr_q;

  localparam logic [NLEV-1:0] ONE = {{(NLEV-1){1'b0}}, 1'b1};

  logic            take, nseoi, seoi, set_ptr, rot_ptr;
  logic [NLEV-1:0] grant_vec, clr_vec;
  assign take      = (ack_set | poll_rd) & int_out;
  assign grant_vec = take ? (ONE << win_level) : '0;
  assign nseoi     = (cmd_valid && (cmd_code == C_NSEOI || cmd_code == C_RNSEOI)) || aeoi_pulse;
  assign seoi      = cmd_valid && (cmd_code == C_SEOI || cmd_code == C_RSEOI);
  assign clr_vec   = ((nseoi && has_eoi) ? (ONE << eoi_lvl) : '0) |
                     (seoi ? (ONE << cmd_level) : '0);
  assign set_ptr   = cmd_valid && (cmd_code == C_SETPRI || cmd_code == C_RSEOI);
  assign rot_ptr   = has_eoi && ((cmd_valid && cmd_code == C_RNSEOI) || (aeoi_pulse && rot_aeoi_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0; isr_q <= '0; req_q <= '1; ptr_q <= '1; rot_aeoi_q <= 1'b0;
    end else if (init_pulse) begin
      irr_q <= '0; isr_q <= '0; req_q <= '1; ptr_q <= '1; rot_aeoi_q <= 1'b0;
    end else begin
      req_q <= req_in;
      irr_q <= level_mode ? (req_in & ~grant_vec)
                          : ((irr_q | (req_in & ~req_q)) & ~grant_vec);
      isr_q <= (isr_q & ~clr_vec) | grant_vec;
      if (cmd_valid && cmd_code == C_RAE_SET)      rot_aeoi_q <= 1'b1;
      else if (cmd_valid && cmd_code == C_RAE_CLR) rot_aeoi_q <= 1'b0;
      if (set_ptr)      ptr_q <= cmd_level;
      else if (rot_ptr) ptr_q <= eoi_lvl;
    end
  end

  assert_int_has_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr_q[win_level] && !mask_in[win_level]));

  assert_ack_enters_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_set || poll_rd) && int_out && !init_pulse && !cmd_valid && !aeoi_pulse)
      |=> isr_q[$past(win_level)]);

  assert_setpri_keeps_isr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_SETPRI && !ack_set && !poll_rd && !aeoi_pulse && !init_pulse)
      |=> isr_q == $past(isr_q));

  assert_rot_specific_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_RSEOI && !init_pulse) |=> ptr_q == $past(cmd_level));

  assert_edge_no_retrigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !init_pulse)
      |=> (irr_q & ~$past(irr_q) & ~$past(req_in & ~req_q)) == '0);

  assert_init_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (irr_q == '0 && isr_q == '0 && !int_out));
endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_pulse = 0, level_mode = 0, sfnm_en = 0, smm_en = 0;
  logic [7:0] mask_in = '0, req_in = '0;
  logic       cmd_valid = 0;
  logic [2:0] cmd_code = '0, cmd_level = '0;
  logic       ack_set = 0, aeoi_pulse = 0, poll_rd = 0;
  logic       int_out;
  logic [2:0] win_level;
  logic [7:0] poll_word, irr_out, isr_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_arbiter #(.NLEV(8)) dut (
    .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse), .level_mode(level_mode),
    .sfnm_en(sfnm_en), .smm_en(smm_en), .mask_in(mask_in), .req_in(req_in),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_level(cmd_level),
    .ack_set(ack_set), .aeoi_pulse(aeoi_pulse), .poll_rd(poll_rd),
    .int_out(int_out), .win_level(win_level), .poll_word(poll_word),
    .irr_out(irr_out), .isr_out(isr_out));

  // op: 0 idle, 1 ack, 2 command, 3 auto end, 4 poll, 5 init
  task automatic step(input logic [7:0] r, input logic [7:0] m, input int op,
                      input logic [2:0] code, input logic [2:0] lvl);
    req_in = r; mask_in = m;
    cmd_valid = (op == 2); cmd_code = code; cmd_level = lvl;
    ack_set = (op == 1); aeoi_pulse = (op == 3); poll_rd = (op == 4); init_pulse = (op == 5);
    @(negedge clk);
    cmd_valid = 0; ack_set = 0; aeoi_pulse = 0; poll_rd = 0; init_pulse = 0;
  endtask

  task automatic chk(input int tag, input logic [7:0] e_irr, input logic [7:0] e_isr,
                     input logic e_int, input logic [2:0] e_win);
    checks++;
    if (irr_out !== e_irr || isr_out !== e_isr || int_out !== e_int || win_level !== e_win) begin
      fails++;
      $display("FAIL R%0d: irr=%h isr=%h int=%b win=%0d expected irr=%h isr=%h int=%b win=%0d",
               tag, irr_out, isr_out, int_out, win_level, e_irr, e_isr, e_int, e_win);
    end
  endtask

  task automatic chk_poll(input int tag, input logic [7:0] e);
    checks++;
    if (poll_word !== e) begin
      fails++;
      $display("FAIL R%0d: poll_word=%h expected %h", tag, poll_word, e);
    end
  endtask

  // {req, mask, op, code, lvl, irr, isr, int, win, tag}
  localparam int NV = 31;
  localparam logic [48:0] TBL [NV] = '{
    {8'h00,8'h00,3'd0,3'd0,3'd0,8'h00,8'h00,1'b0,3'd7,4'd1},  // R1 idle after reset
    {8'h14,8'h00,3'd0,3'd0,3'd0,8'h14,8'h00,1'b1,3'd2,4'd2},  // R2 IR2 beats IR4
    {8'h14,8'h00,3'd1,3'd0,3'd0,8'h10,8'h04,1'b0,3'd4,4'd5},  // R5 ack IR2, IR4 held off
    {8'h15,8'h00,3'd0,3'd0,3'd0,8'h11,8'h04,1'b1,3'd0,4'd2},  // R2 IR0 above service
    {8'h15,8'h00,3'd1,3'd0,3'd0,8'h10,8'h05,1'b0,3'd4,4'd5},  // R5 nested ack
    {8'h15,8'h00,3'd2,3'd1,3'd0,8'h10,8'h04,1'b0,3'd4,4'd6},  // R6 clears IR0
    {8'h15,8'h00,3'd2,3'd1,3'd0,8'h10,8'h00,1'b1,3'd4,4'd6},  // R6 clears IR2
    {8'h15,8'h00,3'd1,3'd0,3'd0,8'h00,8'h10,1'b0,3'd7,4'd5},  // R5 ack IR4
    {8'h15,8'h00,3'd2,3'd5,3'd0,8'h00,8'h00,1'b0,3'd7,4'd8},  // R8 rotate, IR4 lowest
    {8'h00,8'h00,3'd0,3'd0,3'd0,8'h00,8'h00,1'b0,3'd7,4'd4},  // R4 drop inputs
    {8'h21,8'h00,3'd0,3'd0,3'd0,8'h21,8'h00,1'b1,3'd5,4'd8},  // R8 IR5 now first
    {8'h21,8'h00,3'd1,3'd0,3'd0,8'h01,8'h20,1'b0,3'd0,4'd8},  // R8 IR0 ranks below IR5
    {8'h21,8'h00,3'd2,3'd7,3'd5,8'h01,8'h00,1'b1,3'd0,4'd8},  // R8 rotate specific 5
    {8'h21,8'h00,3'd1,3'd0,3'd0,8'h00,8'h01,1'b0,3'd7,4'd5},  // R5 ack IR0
    {8'h21,8'h00,3'd2,3'd3,3'd0,8'h00,8'h00,1'b0,3'd7,4'd7},  // R7 specific end, held inputs no retrigger
    {8'h00,8'h00,3'd0,3'd0,3'd0,8'h00,8'h00,1'b0,3'd7,4'd4},  // R4
    {8'h03,8'h01,3'd0,3'd0,3'd0,8'h03,8'h00,1'b1,3'd1,4'd3},  // R3 IR0 masked
    {8'h03,8'h03,3'd0,3'd0,3'd0,8'h03,8'h00,1'b0,3'd7,4'd3},  // R3 all masked
    {8'h03,8'h00,3'd2,3'd6,3'd0,8'h03,8'h00,1'b1,3'd1,4'd9},  // R9 IR0 lowest
    {8'h03,8'h00,3'd1,3'd0,3'd0,8'h01,8'h02,1'b0,3'd0,4'd5},  // R5 ack IR1
    {8'h03,8'h00,3'd2,3'd6,3'd1,8'h01,8'h02,1'b1,3'd0,4'd9},  // R9 IR1 lowest, service kept
    {8'h03,8'h00,3'd2,3'd1,3'd0,8'h01,8'h00,1'b1,3'd0,4'd6},  // R6
    {8'h03,8'h00,3'd1,3'd0,3'd0,8'h00,8'h01,1'b0,3'd7,4'd5},  // R5
    {8'h03,8'h00,3'd2,3'd4,3'd0,8'h00,8'h01,1'b0,3'd7,4'd10}, // R10 enable rotation
    {8'h03,8'h00,3'd3,3'd0,3'd0,8'h00,8'h00,1'b0,3'd7,4'd10}, // R10 auto end, IR0 lowest
    {8'h00,8'h00,3'd0,3'd0,3'd0,8'h00,8'h00,1'b0,3'd7,4'd10}, // R10
    {8'h03,8'h00,3'd0,3'd0,3'd0,8'h03,8'h00,1'b1,3'd1,4'd10}, // R10 IR1 first
    {8'h03,8'h00,3'd1,3'd0,3'd0,8'h01,8'h02,1'b0,3'd0,4'd5},  // R5
    {8'h03,8'h00,3'd2,3'd0,3'd0,8'h01,8'h02,1'b0,3'd0,4'd10}, // R10 disable rotation
    {8'h03,8'h00,3'd3,3'd0,3'd0,8'h01,8'h00,1'b1,3'd0,4'd10}, // R10 auto end clears
    {8'h03,8'h00,3'd2,3'd2,3'd0,8'h01,8'h00,1'b1,3'd0,4'd9}   // R9 no-op code
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(1, 8'h00, 8'h00, 1'b0, 3'd7); // R1 reset state
    for (int i = 0; i < NV; i++) begin
      step(TBL[i][48:41], TBL[i][40:33], int'(TBL[i][32:30]), TBL[i][29:27], TBL[i][26:24]);
      chk(int'(TBL[i][3:0]), TBL[i][23:16], TBL[i][15:8], TBL[i][7], TBL[i][6:4]);
    end

    // R1 reset again
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk(1, 8'h00, 8'h00, 1'b0, 3'd7);

    // R4 level capture
    level_mode = 1;
    step(8'h08, 8'h00, 0, 3'd0, 3'd0); chk(4, 8'h08, 8'h00, 1'b1, 3'd3);
    step(8'h08, 8'h00, 1, 3'd0, 3'd0); chk(4, 8'h00, 8'h08, 1'b0, 3'd7);
    step(8'h08, 8'h00, 0, 3'd0, 3'd0); chk(4, 8'h08, 8'h08, 1'b0, 3'd3);
    step(8'h00, 8'h00, 0, 3'd0, 3'd0); chk(4, 8'h00, 8'h08, 1'b0, 3'd7);
    step(8'h00, 8'h00, 2, 3'd3, 3'd3); chk(7, 8'h00, 8'h00, 1'b0, 3'd7);
    level_mode = 0;

    // R3 and R6 special mask mode
    step(8'h04, 8'h00, 0, 3'd0, 3'd0); chk(2, 8'h04, 8'h00, 1'b1, 3'd2);
    step(8'h04, 8'h00, 1, 3'd0, 3'd0); chk(5, 8'h00, 8'h04, 1'b0, 3'd7);
    step(8'h14, 8'h00, 0, 3'd0, 3'd0); chk(2, 8'h10, 8'h04, 1'b0, 3'd4);
    smm_en = 1; #1;                    chk(3, 8'h10, 8'h04, 1'b1, 3'd4);
    step(8'h14, 8'h00, 1, 3'd0, 3'd0); chk(5, 8'h00, 8'h14, 1'b0, 3'd7);
    step(8'h14, 8'h04, 2, 3'd1, 3'd0); chk(6, 8'h00, 8'h04, 1'b0, 3'd7);
    smm_en = 0;
    step(8'h14, 8'h00, 2, 3'd1, 3'd0); chk(6, 8'h00, 8'h00, 1'b0, 3'd7);

    // R12 special nested mode
    step(8'h00, 8'h00, 0, 3'd0, 3'd0);
    step(8'h08, 8'h00, 0, 3'd0, 3'd0);
    step(8'h08, 8'h00, 1, 3'd0, 3'd0); chk(5, 8'h00, 8'h08, 1'b0, 3'd7);
    step(8'h00, 8'h00, 0, 3'd0, 3'd0);
    step(8'h08, 8'h00, 0, 3'd0, 3'd0); chk(12, 8'h08, 8'h08, 1'b0, 3'd3);
    sfnm_en = 1; #1;                   chk(12, 8'h08, 8'h08, 1'b1, 3'd3);
    sfnm_en = 0;

    // R11 poll read
    step(8'h08, 8'h00, 2, 3'd3, 3'd3); chk(7, 8'h08, 8'h00, 1'b1, 3'd3);
    chk_poll(11, 8'h83);
    step(8'h08, 8'h00, 4, 3'd0, 3'd0); chk(11, 8'h00, 8'h08, 1'b0, 3'd7);
    chk_poll(11, 8'h00);

    // R13 initialization
    step(8'h08, 8'h00, 2, 3'd6, 3'd2);
    step(8'h08, 8'h00, 5, 3'd0, 3'd0); chk(13, 8'h00, 8'h00, 1'b0, 3'd7);
    step(8'h08, 8'h00, 0, 3'd0, 3'd0); chk(13, 8'h00, 8'h00, 1'b0, 3'd7);
    step(8'h00, 8'h00, 0, 3'd0, 3'd0);
    step(8'h0C, 8'h00, 0, 3'd0, 3'd0); chk(13, 8'h0C, 8'h00, 1'b1, 3'd2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule